// File: doc/BRIEF.md
# Bonded or Independent Lane Deserializer

This block widens a 16-bit receive line bus that arrives as four 4-bit lanes. Each lane has its own clock. A static configuration picks one of two organisations. In the bonded organisation, the whole bus is one 16-bit channel clocked by lane 0, and the other three lane clocks have no effect on it. In the independent organisation, each lane is a 4-bit channel of its own, running in its own clock domain and with no phase or frequency relation to the other lanes.

A second static input sets the widening ratio to 4 or 8. Each channel gathers that many input words into one output word. The earliest word received lands in the most significant position. When a word is complete, the channel raises a one-cycle strobe. It also produces a divided clock at its input rate over the ratio. Every lane has its own synchronous reset in its own domain. Configuration may change only while the resets are held.

Top module: `lane_deser_top`

## Requirements
- R1: While a lane's reset is high, the outputs of that lane's channel are all zero: word, strobe and divided clock. The bonded channel follows the reset of lane 0.
- R2: Bonded mode, ratio 8 (`cfg_bonded`=1, `cfg_ratio8`=1): eight successive 16-bit bus samples form `bond_word`. The first sample is in bits 127:112 and the last is in bits 15:0.
- R3: Bonded mode, ratio 4 (`cfg_ratio8`=0): four samples form `bond_word[63:0]`, with the first in bits 63:48. Bits 127:64 are zero.
- R4: Independent mode, ratio 8 (`cfg_bonded`=0): lane i (bus bits 4i+3:4i) gathers eight nibbles into `quad_word[32i+31:32i]`, with the first nibble in the top four bits of that slice.
- R5: Independent mode, ratio 4: lane i gathers four nibbles into the low 16 bits of its slice, with the first nibble in bits 15:12 of the slice. The upper 16 bits of the slice are zero.
- R6: A channel's strobe is high for exactly one clock when a word completes. Successive strobes are exactly ratio clocks apart. The word does not change between strobes.
- R7: Each divided clock has a period of ratio input clocks and is high for the first half of each period. It is high in the cycle of every strobe.
- R8: In bonded mode the independent outputs stay idle, and lane clocks 1 to 3 do not affect the bonded result. In independent mode the bonded outputs stay idle.
- R9: After a channel leaves reset, its first output word contains exactly the first ratio samples taken after the release. Resetting one lane in independent mode does not disturb the other lanes.
- R10: In independent mode, the four lanes produce correct words while their clocks run at unrelated periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_clk | input | 4 | Per-lane receive clock; bit 0 also clocks the bonded channel |
| lane_rst | input | 4 | Per-lane active-high synchronous reset, each in its own lane domain |
| cfg_bonded | input | 1 | 1 selects the bonded 16-bit channel, 0 selects four independent lanes |
| cfg_ratio8 | input | 1 | 1 selects widening by 8, 0 selects widening by 4 |
| line_data | input | 16 | Receive bus; lane i uses bits 4i+3:4i |
| bond_word | output | 128 | Bonded output word |
| bond_valid | output | 1 | Bonded word-complete strobe |
| bond_div_clk | output | 1 | Bonded divided clock |
| quad_word | output | 128 | Four 32-bit per-lane output words, lane i at bits 32i+31:32i |
| quad_valid | output | 4 | Per-lane word-complete strobes |
| quad_div_clk | output | 4 | Per-lane divided clocks |

## Verification
The bench resets a single lane in the middle of a word while the other lanes keep running. A design whose reset missed the gather counter would emit a first word that is short or misaligned. A design that shared state between lanes would corrupt the neighbours. The bench also switches the ratio from 8 to 4 under reset. This catches stale upper bits left in the bonded word and strobes spaced eight clocks apart instead of four. In bonded mode the three upper lane clocks keep toggling, and the bench watches both result paths. A channel wired to the wrong clock, or an idle path that still fires, would show up as unexpected strobes or mismatched words.

// File: rtl/lane_deser_pkg.sv
`timescale 1ns/100ps
package lane_deser_pkg;

  // Position of the final sample in a word for the selected ratio.
  function automatic int last_idx(input logic ratio8, input int rmax);
    return ratio8 ? rmax - 1 : (rmax / 2) - 1;
  endfunction

  // Divided clock level for a gather position (high in the first half).
  function automatic logic div_level(input int pos, input logic ratio8, input int rmax);
    return (pos < (ratio8 ? rmax / 2 : rmax / 4));
  endfunction

endpackage

// File: rtl/lane_phase_ctr.sv
`timescale 1ns/100ps
module lane_phase_ctr
  import lane_deser_pkg::*;
#(
  parameter int RATIO_MAX = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ratio8,
  output logic word_done,
  output logic div_clk
);
  localparam int CNT_W = $clog2(RATIO_MAX);

  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] pos_nxt;
  logic [CNT_W-1:0] last_pos;
  logic             wrap;

  assign last_pos  = CNT_W'(last_idx(ratio8, RATIO_MAX));
  assign wrap      = (pos == last_pos);
  assign pos_nxt   = wrap ? '0 : pos + CNT_W'(1);
  assign word_done = en & wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      div_clk <= 1'b0;
    end else if (en) begin
      pos     <= pos_nxt;
      div_clk <= div_level(int'(pos_nxt), ratio8, RATIO_MAX);
    end else begin
      div_clk <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_gather.sv
`timescale 1ns/100ps
module lane_gather #(
  parameter int IN_W      = 4,
  parameter int RATIO_MAX = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      ratio8,
  input  logic [IN_W-1:0]           din,
  output logic [IN_W*RATIO_MAX-1:0] word,
  output logic                      valid,
  output logic                      div_clk
);
  localparam int OUT_W  = IN_W * RATIO_MAX;
  localparam int HALF_W = OUT_W / 2;

  logic [OUT_W-1:0] shreg;
  logic [OUT_W-1:0] shreg_nxt;
  logic             word_done;

  assign shreg_nxt = {shreg[OUT_W-IN_W-1:0], din};

  lane_phase_ctr #(.RATIO_MAX(RATIO_MAX)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .ratio8    (ratio8),
    .word_done (word_done),
    .div_clk   (div_clk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= word_done;
      if (en) shreg <= shreg_nxt;
      if (word_done)
        word <= ratio8 ? shreg_nxt : {{HALF_W{1'b0}}, shreg_nxt[HALF_W-1:0]};
    end
  end
endmodule

// File: rtl/lane_deser_top.sv
`timescale 1ns/100ps
module lane_deser_top #(
  parameter int LANES     = 4,
  parameter int LANE_W    = 4,
  parameter int RATIO_MAX = 8
) (
  input  logic [LANES-1:0]                  lane_clk,
  input  logic [LANES-1:0]                  lane_rst,
  input  logic                              cfg_bonded,
  input  logic                              cfg_ratio8,
  input  logic [LANES*LANE_W-1:0]           line_data,
  output logic [LANES*LANE_W*RATIO_MAX-1:0] bond_word,
  output logic                              bond_valid,
  output logic                              bond_div_clk,
  output logic [LANES*LANE_W*RATIO_MAX-1:0] quad_word,
  output logic [LANES-1:0]                  quad_valid,
  output logic [LANES-1:0]                  quad_div_clk
);
  localparam int BUS_W      = LANES * LANE_W;
  localparam int LANE_OUT_W = LANE_W * RATIO_MAX;

  logic bond_en;
  logic lane_en;

  assign bond_en = cfg_bonded;
  assign lane_en = ~cfg_bonded;

  // Bonded channel: whole bus on lane 0 clock and reset.
  lane_gather #(.IN_W(BUS_W), .RATIO_MAX(RATIO_MAX)) u_bond (
    .clk     (lane_clk[0]),
    .rst     (lane_rst[0]),
    .en      (bond_en),
    .ratio8  (cfg_ratio8),
    .din     (line_data),
    .word    (bond_word),
    .valid   (bond_valid),
    .div_clk (bond_div_clk)
  );

  // Independent channels, one per lane domain.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_gather #(.IN_W(LANE_W), .RATIO_MAX(RATIO_MAX)) u_lane (
      .clk     (lane_clk[l]),
      .rst     (lane_rst[l]),
      .en      (lane_en),
      .ratio8  (cfg_ratio8),
      .din     (line_data[l*LANE_W +: LANE_W]),
      .word    (quad_word[l*LANE_OUT_W +: LANE_OUT_W]),
      .valid   (quad_valid[l]),
      .div_clk (quad_div_clk[l])
    );
  end
endmodule

// File: rtl/lane_deser_chk.sv
`timescale 1ns/100ps
module lane_deser_chk #(
  parameter int LANES     = 4,
  parameter int LANE_W    = 4,
  parameter int RATIO_MAX = 8
) (
  input logic [LANES-1:0]                  lane_clk,
  input logic [LANES-1:0]                  lane_rst,
  input logic                              cfg_bonded,
  input logic                              cfg_ratio8,
  input logic [LANES*LANE_W*RATIO_MAX-1:0] bond_word,
  input logic                              bond_valid,
  input logic                              bond_div_clk,
  input logic [LANES*LANE_W*RATIO_MAX-1:0] quad_word,
  input logic [LANES-1:0]                  quad_valid,
  input logic [LANES-1:0]                  quad_div_clk
);
  localparam int BOND_W  = LANES * LANE_W * RATIO_MAX;
  localparam int LOUT_W  = LANE_W * RATIO_MAX;

  AST_BOND_STROBE_DIV: assert property (@(posedge lane_clk[0]) disable iff (lane_rst[0])
    bond_valid |-> bond_div_clk); // R7
  AST_BOND_STROBE_SINGLE: assert property (@(posedge lane_clk[0]) disable iff (lane_rst[0])
    bond_valid |=> !bond_valid); // R6
  AST_BOND_HOLD: assert property (@(posedge lane_clk[0]) disable iff (lane_rst[0])
    !bond_valid |-> $stable(bond_word)); // R6
  AST_BOND_IDLE_IN_QUAD: assert property (@(posedge lane_clk[0]) disable iff (lane_rst[0])
    !cfg_bonded |-> (!bond_valid && !bond_div_clk)); // R8
  AST_BOND_R4_TOP_ZERO: assert property (@(posedge lane_clk[0]) disable iff (lane_rst[0])
    !cfg_ratio8 |-> (bond_word[BOND_W-1:BOND_W/2] == '0)); // R3

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_LANE_STROBE_DIV: assert property (@(posedge lane_clk[l]) disable iff (lane_rst[l])
      quad_valid[l] |-> quad_div_clk[l]); // R7
    AST_LANE_HOLD: assert property (@(posedge lane_clk[l]) disable iff (lane_rst[l])
      !quad_valid[l] |-> $stable(quad_word[l*LOUT_W +: LOUT_W])); // R6
    AST_LANE_IDLE_IN_BOND: assert property (@(posedge lane_clk[l]) disable iff (lane_rst[l])
      cfg_bonded |-> (!quad_valid[l] && !quad_div_clk[l])); // R8
    AST_LANE_R4_TOP_ZERO: assert property (@(posedge lane_clk[l]) disable iff (lane_rst[l])
      !cfg_ratio8 |-> (quad_word[l*LOUT_W + LOUT_W/2 +: LOUT_W/2] == '0)); // R5
  end
endmodule

bind lane_deser_top lane_deser_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .RATIO_MAX(RATIO_MAX)
) u_chk (
  .lane_clk     (lane_clk),
  .lane_rst     (lane_rst),
  .cfg_bonded   (cfg_bonded),
  .cfg_ratio8   (cfg_ratio8),
  .bond_word    (bond_word),
  .bond_valid   (bond_valid),
  .bond_div_clk (bond_div_clk),
  .quad_word    (quad_word),
  .quad_valid   (quad_valid),
  .quad_div_clk (quad_div_clk)
);

// File: tb/lane_deser_top_tb.sv
`timescale 1ns/100ps
module lane_deser_top_tb;
  wire  [3:0]   lane_clk;
  wire  [3:0]   lane_rst;
  wire  [15:0]  line_data;
  logic         cfg_bonded = 1'b1;
  logic         cfg_ratio8 = 1'b1;
  logic [3:0]   rst_req    = 4'hF;
  logic [15:0]  bond_d     = '0;
  logic [127:0] bond_word;
  logic         bond_valid;
  logic         bond_div_clk;
  logic [127:0] quad_word;
  logic [3:0]   quad_valid;
  logic [3:0]   quad_div_clk;

  int    checks = 0;
  int    errors = 0;
  string wtag   = "R2";
  event  drain_ev;

  lane_deser_top u_dut (
    .lane_clk(lane_clk), .lane_rst(lane_rst), .cfg_bonded(cfg_bonded),
    .cfg_ratio8(cfg_ratio8), .line_data(line_data), .bond_word(bond_word),
    .bond_valid(bond_valid), .bond_div_clk(bond_div_clk), .quad_word(quad_word),
    .quad_valid(quad_valid), .quad_div_clk(quad_div_clk)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-lane clock, driver, reference queue and monitor.
  for (genvar i = 0; i < 4; i++) begin : g_lane
    localparam int HALF = (i == 0) ? 10 : (i == 1) ? 13 : (i == 2) ? 17 : 23;
    logic        c = 1'b0;
    logic        r = 1'b1;
    logic [3:0]  d = '0;
    logic [31:0] q[$];
    logic [31:0] acc = '0;
    logic [31:0] last_w = '0;
    logic [31:0] exp_w;
    int          cnt = 0;
    int          gap = 0;
    int          seen = 0;
    bit          have = 0;

    assign lane_clk[i] = c;
    assign lane_rst[i] = r;
    assign line_data[4*i +: 4] = cfg_bonded ? bond_d[4*i +: 4] : d;

    initial begin
      #(i * 3);
      forever #(HALF) c = ~c;
    end

    always @(negedge c) begin
      // monitor, using the reset the DUT saw at the last edge
      if (!r) begin
        if (cfg_bonded) begin
          if (quad_valid[i] || quad_div_clk[i]) chk(0, "R8 lane busy in bonded", 128'(quad_valid[i]), 0);
        end else begin
          gap++;
          if (quad_valid[i]) begin
            if (q.size() == 0) chk(0, {wtag, " unexpected lane word"}, 128'(quad_word[32*i +: 32]), 0);
            else begin
              exp_w = q.pop_front();
              chk(quad_word[32*i +: 32] === exp_w, {wtag, " lane word"}, 128'(quad_word[32*i +: 32]), 128'(exp_w));
            end
            chk(quad_div_clk[i] === 1'b1, "R7 lane div high at strobe", 128'(quad_div_clk[i]), 1);
            if (have) chk(gap == (cfg_ratio8 ? 8 : 4), "R6 lane strobe spacing", 128'(gap), 128'(cfg_ratio8 ? 8 : 4));
            have = 1; gap = 0; seen++;
            last_w = quad_word[32*i +: 32];
          end else if (have) begin
            if (quad_word[32*i +: 32] !== last_w)
              chk(0, "R6 lane word held", 128'(quad_word[32*i +: 32]), 128'(last_w));
          end
        end
      end else begin
        have = 0; gap = 0; seen = 0;
      end
      // driver and reference model
      r = rst_req[i];
      if (r) begin
        cnt = 0; acc = '0;
      end else if (!cfg_bonded) begin
        d = 4'($urandom);
        acc = {acc[27:0], d};
        cnt++;
        if (cnt == (cfg_ratio8 ? 8 : 4)) begin
          q.push_back(cfg_ratio8 ? acc : {16'h0, acc[15:0]});
          cnt = 0;
        end
      end
    end

    always @(drain_ev) chk(q.size() == 0, "R10 lane queue drained", 128'(q.size()), 0);
  end

  // Bonded scoreboard on lane 0 clock.
  logic [127:0] bond_q[$];
  logic [127:0] bacc = '0;
  logic [127:0] blast = '0;
  logic [127:0] bexp;
  bit           br = 1'b1;
  bit           bhave = 0;
  int           bcnt = 0;
  int           bgap = 0;
  int           bond_seen = 0;

  always @(negedge lane_clk[0]) begin
    if (!br) begin
      if (!cfg_bonded) begin
        if (bond_valid || bond_div_clk) chk(0, "R8 bonded busy in quad", 128'(bond_valid), 0);
      end else begin
        bgap++;
        if (bond_valid) begin
          if (bond_q.size() == 0) chk(0, {wtag, " unexpected bonded word"}, bond_word, 0);
          else begin
            bexp = bond_q.pop_front();
            chk(bond_word === bexp, {wtag, " bonded word"}, bond_word, bexp);
          end
          chk(bond_div_clk === 1'b1, "R7 bonded div high at strobe", 128'(bond_div_clk), 1);
          if (bhave) chk(bgap == (cfg_ratio8 ? 8 : 4), "R6 bonded strobe spacing", 128'(bgap), 128'(cfg_ratio8 ? 8 : 4));
          bhave = 1; bgap = 0; bond_seen++;
          blast = bond_word;
        end else if (bhave && bond_word !== blast) begin
          chk(0, "R6 bonded word held", bond_word, blast);
        end
      end
    end else begin
      bhave = 0; bgap = 0; bond_seen = 0;
    end
    br = rst_req[0];
    if (br) begin
      bcnt = 0; bacc = '0;
    end else if (cfg_bonded) begin
      bond_d = 16'($urandom);
      bacc = {bacc[111:0], bond_d};
      bcnt++;
      if (bcnt == (cfg_ratio8 ? 8 : 4)) begin
        bond_q.push_back(cfg_ratio8 ? bacc : {64'h0, bacc[63:0]});
        bcnt = 0;
      end
    end
  end

  function automatic bit all_seen(input int n);
    return g_lane[0].seen >= n && g_lane[1].seen >= n && g_lane[2].seen >= n && g_lane[3].seen >= n;
  endfunction

  task automatic slow_wait(input int n);
    repeat (n) @(posedge lane_clk[3]);
    #0.5;
  endtask

  task automatic hold_and_drain();
    rst_req = 4'hF;
    slow_wait(4);
    chk(bond_q.size() == 0, "R2 bonded queue drained", 128'(bond_q.size()), 0);
    ->drain_ev;
    #1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    chk(0, "R6 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // R1: reset state
    slow_wait(4);
    chk(bond_word === '0 && bond_valid === 1'b0 && bond_div_clk === 1'b0, "R1 bonded reset", bond_word, 0);
    chk(quad_word === '0, "R1 lane words reset", quad_word, 0);
    chk(quad_valid === '0 && quad_div_clk === '0, "R1 lane strobes reset", 128'({quad_valid, quad_div_clk}), 0);

    // Bonded, ratio 8; upper lane clocks keep running (R8)
    wtag = "R2"; rst_req = 4'h0;
    while (bond_seen < 5) @(posedge lane_clk[0]);
    #0.5; hold_and_drain();

    // Bonded, ratio 4, then mid-word reset of lane 0
    cfg_ratio8 = 1'b0; wtag = "R3"; rst_req = 4'h0;
    while (bond_seen < 5) @(posedge lane_clk[0]);
    @(posedge bond_valid);
    repeat (2) @(posedge lane_clk[0]);
    #0.5; rst_req[0] = 1'b1;
    repeat (3) @(posedge lane_clk[0]);
    #0.5; rst_req[0] = 1'b0; wtag = "R9 bonded";
    while (bond_seen < 3) @(posedge lane_clk[0]);
    #0.5; hold_and_drain();

    // Independent lanes, ratio 8, unrelated clocks
    cfg_bonded = 1'b0; cfg_ratio8 = 1'b1; wtag = "R4/R10"; rst_req = 4'h0;
    while (!all_seen(4)) @(posedge lane_clk[3]);
    #0.5; hold_and_drain();

    // Independent lanes, ratio 4, with a reset of lane 2 alone
    cfg_ratio8 = 1'b0; wtag = "R5"; rst_req = 4'h0;
    while (!all_seen(3)) @(posedge lane_clk[3]);
    @(posedge lane_clk[2]); @(posedge lane_clk[2]);
    #0.5; rst_req[2] = 1'b1;
    repeat (3) @(posedge lane_clk[2]);
    #0.5; rst_req[2] = 1'b0; wtag = "R5/R9";
    while (!all_seen(3)) @(posedge lane_clk[3]);
    while (g_lane[0].seen < 10) @(posedge lane_clk[0]);
    #0.5; hold_and_drain();

    finish_run();
  end
endmodule